// File: doc/BRIEF.md
# Special-Register Move Unit

This unit serves the two special-register move operations of a small microcontroller-class core. A read copies a special register onto a 32-bit result bus. A write turns a general-register value into write enables, and the state elements outside the unit load those enables on the next rising clock edge. The special registers are the combined program status word (seen through eight selector views), the main and process stack pointers, the fault-mask bit and the CONTROL register. The state itself lives outside the unit. It arrives as inputs: the status word, the live stack register, its banked copy, the fault mask and CONTROL.

Privilege gates every access. Unprivileged code can read the status views and CONTROL, and can write only the condition flags. Every other unprivileged access reads as zero or is dropped without notice. A selector that names no implemented register reads as zero and causes no write. It also raises a one-cycle error pulse rather than halting the core.

Each access finishes in the cycle of its strobe. There is no back-pressure, so the strobes carry no ready signal. The `clk` and `rst_n` pins only time the attached property checks. All results from the unit are combinational.

Top module: `sreg_access_unit`

## Requirements
- R1: For selectors 0 to 7, a read includes status bits [31:27] (the condition flags) when selector bit 2 is 0, and returns them as 0 when selector bit 2 is 1.
- R2: For selectors 0 to 7, a read includes status bits [8:0] (the exception number) only when selector bit 0 is 1 and the access is privileged. Otherwise those bits read as 0.
- R3: For selectors 0 to 7, status bits [26:9] always read as 0.
- R4: Selector 20 (CONTROL) reads `ctrl_in` zero-extended, at either privilege level.
- R5: An unprivileged read of selector 8, 9 or 19 returns 0 and raises no error.
- R6: A privileged read of selector 8 (main stack pointer) returns `sp_live` when `ctrl_in[1]` is 0 and `sp_banked` when it is 1. Selector 9 (process stack pointer) returns the reverse.
- R7: A privileged read of selector 19 returns `fmask_in` in bit 0, with all other bits 0.
- R8: A write to selectors 0 to 7 changes only status bits [31:27], and does so only when selector bit 2 is 0. It is allowed at either privilege level and takes effect at the next clock edge.
- R9: An unprivileged write to selector 8, 9, 19 or 20 changes no state and raises no error.
- R10: Privileged writes: selector 8 or 9 loads the live register if that pointer is active and the banked copy otherwise; selector 19 loads bit 0 of the data; selector 20 loads bits [1:0]. At most one write enable is high in any cycle.
- R11: A privileged write to selector 20 whose data bit 1 differs from `ctrl_in[1]` raises `sp_swap` in the same cycle. The environment then exchanges the live and banked stack pointers.
- R12: Any access to a selector outside 0 to 9, 19 and 20 reads 0, asserts no write enable and raises `sel_err` in that cycle only.
- R13: `rdata` is 0 while `rd_en` is low, and `st_wdata` is 0 while `wr_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the property checks |
| rst_n | input | 1 | Active-low reset; the checks are off while it is low |
| sel | input | 8 | Special-register selector |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Value to be written |
| priv | input | 1 | 1 for a privileged access |
| psw_in | input | 32 | Current status word |
| sp_live | input | 32 | Active stack register |
| sp_banked | input | 32 | Inactive (banked) stack pointer |
| fmask_in | input | 1 | Current fault-mask bit |
| ctrl_in | input | 2 | Current CONTROL; bit 1 set means the process pointer is active |
| rdata | output | 32 | Read result |
| psw_we | output | 1 | Status word load enable |
| psw_wmask | output | 32 | Bits of the status word to load from `st_wdata` |
| live_sp_we | output | 1 | Live stack register load enable |
| banked_sp_we | output | 1 | Banked stack pointer load enable |
| fmask_we | output | 1 | Fault-mask load enable (from bit 0) |
| ctrl_we | output | 1 | CONTROL load enable (from bits [1:0]) |
| sp_swap | output | 1 | Request to exchange the live and banked pointers |
| st_wdata | output | 32 | Write value for the state elements, gated by `wr_en` |
| sel_err | output | 1 | Unknown-selector pulse |

## Verification
Read data, write enables, the swap request and the error pulse are all due in the same cycle as the strobe. The bench drives the strobe at a falling edge and samples these results 1 ns later, before the next rising edge. The state changes that a write causes appear only after that rising edge, so the bench modelled state is compared 1 ns past it. The bench confirms that the error pulse is one cycle long by sampling `sel_err` again in the idle cycle that follows.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  typedef enum logic [2:0] {
    TGT_PSW,
    TGT_MAIN_SP,
    TGT_PROC_SP,
    TGT_FMASK,
    TGT_CTRL,
    TGT_NONE
  } tgt_e;

  localparam int unsigned PSW_VIEWS       = 8;
  localparam int unsigned SEL_MAIN_SP     = 8;
  localparam int unsigned SEL_PROC_SP     = 9;
  localparam int unsigned SEL_FMASK       = 19;
  localparam int unsigned SEL_CTRL        = 20;
  localparam int unsigned VIEW_NOFLAG_BIT = 2;
  localparam int unsigned VIEW_EXC_BIT    = 0;
endpackage

// File: rtl/sreg_sel_decode.sv
module sreg_sel_decode
  import sreg_pkg::*;
#(
  parameter int unsigned SEL_W = 8
) (
  input  logic [SEL_W-1:0] sel,
  output tgt_e             tgt
);
  always_comb begin
    if (sel < SEL_W'(PSW_VIEWS)) begin
      tgt = TGT_PSW;
    end else begin
      case (sel)
        SEL_W'(SEL_MAIN_SP): tgt = TGT_MAIN_SP;
        SEL_W'(SEL_PROC_SP): tgt = TGT_PROC_SP;
        SEL_W'(SEL_FMASK):   tgt = TGT_FMASK;
        SEL_W'(SEL_CTRL):    tgt = TGT_CTRL;
        default:             tgt = TGT_NONE;
      endcase
    end
  end
endmodule

// File: rtl/sreg_read_mux.sv
module sreg_read_mux
  import sreg_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned FLAG_LO = 27,
  parameter int unsigned EXC_W   = 9,
  parameter int unsigned CTRL_W  = 2
) (
  input  tgt_e              tgt,
  input  logic              view_noflag,
  input  logic              view_exc,
  input  logic              priv,
  input  logic              rd_en,
  input  logic              proc_active,
  input  logic [DATA_W-1:0] psw_in,
  input  logic [DATA_W-1:0] sp_live,
  input  logic [DATA_W-1:0] sp_banked,
  input  logic              fmask_in,
  input  logic [CTRL_W-1:0] ctrl_in,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [DATA_W-1:0] ONE       = DATA_W'(1);
  localparam logic [DATA_W-1:0] FLAG_MASK = ~((ONE << FLAG_LO) - ONE);
  localparam logic [DATA_W-1:0] EXC_MASK  = (ONE << EXC_W) - ONE;

  logic [DATA_W-1:0] view_mask;

  // the execution-state bits sit in neither mask, so they always read as zero
  always_comb begin
    view_mask = '0;
    if (!view_noflag)
      view_mask = view_mask | FLAG_MASK;
    if (view_exc && priv)
      view_mask = view_mask | EXC_MASK;
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (tgt)
        TGT_PSW:     rdata = psw_in & view_mask;
        TGT_CTRL:    rdata = DATA_W'(ctrl_in);
        TGT_MAIN_SP: if (priv) rdata = proc_active ? sp_banked : sp_live;
        TGT_PROC_SP: if (priv) rdata = proc_active ? sp_live : sp_banked;
        TGT_FMASK:   if (priv) rdata = DATA_W'(fmask_in);
        default:     rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/sreg_write_ctl.sv
module sreg_write_ctl
  import sreg_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned FLAG_LO = 27
) (
  input  tgt_e              tgt,
  input  logic              view_noflag,
  input  logic              priv,
  input  logic              wr_en,
  input  logic              proc_active,
  input  logic              new_spsel,
  output logic              psw_we,
  output logic [DATA_W-1:0] psw_wmask,
  output logic              live_sp_we,
  output logic              banked_sp_we,
  output logic              fmask_we,
  output logic              ctrl_we,
  output logic              sp_swap
);
  localparam logic [DATA_W-1:0] ONE       = DATA_W'(1);
  localparam logic [DATA_W-1:0] FLAG_MASK = ~((ONE << FLAG_LO) - ONE);

  always_comb begin
    psw_we       = 1'b0;
    psw_wmask    = '0;
    live_sp_we   = 1'b0;
    banked_sp_we = 1'b0;
    fmask_we     = 1'b0;
    ctrl_we      = 1'b0;
    sp_swap      = 1'b0;
    if (wr_en) begin
      case (tgt)
        TGT_PSW: begin
          // flags are the only writable status bits, and only through flag views
          if (!view_noflag) begin
            psw_we    = 1'b1;
            psw_wmask = FLAG_MASK;
          end
        end
        TGT_MAIN_SP: begin
          live_sp_we   = priv && !proc_active;
          banked_sp_we = priv && proc_active;
        end
        TGT_PROC_SP: begin
          live_sp_we   = priv && proc_active;
          banked_sp_we = priv && !proc_active;
        end
        TGT_FMASK: fmask_we = priv;
        TGT_CTRL: begin
          ctrl_we = priv;
          sp_swap = priv && (new_spsel != proc_active);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sreg_access_unit.sv
module sreg_access_unit
  import sreg_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned SEL_W     = 8,
  parameter int unsigned FLAG_LO   = 27,
  parameter int unsigned EXC_W     = 9,
  parameter int unsigned CTRL_W    = 2,
  parameter int unsigned SPSEL_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  sel,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              priv,
  input  logic [DATA_W-1:0] psw_in,
  input  logic [DATA_W-1:0] sp_live,
  input  logic [DATA_W-1:0] sp_banked,
  input  logic              fmask_in,
  input  logic [CTRL_W-1:0] ctrl_in,
  output logic [DATA_W-1:0] rdata,
  output logic              psw_we,
  output logic [DATA_W-1:0] psw_wmask,
  output logic              live_sp_we,
  output logic              banked_sp_we,
  output logic              fmask_we,
  output logic              ctrl_we,
  output logic              sp_swap,
  output logic [DATA_W-1:0] st_wdata,
  output logic              sel_err
);
  tgt_e tgt;
  logic view_noflag;
  logic view_exc;
  logic proc_active;

  assign view_noflag = sel[VIEW_NOFLAG_BIT];
  assign view_exc    = sel[VIEW_EXC_BIT];
  assign proc_active = ctrl_in[SPSEL_BIT];

  sreg_sel_decode #(.SEL_W(SEL_W)) u_decode (
    .sel (sel),
    .tgt (tgt)
  );

  sreg_read_mux #(
    .DATA_W (DATA_W),
    .FLAG_LO(FLAG_LO),
    .EXC_W  (EXC_W),
    .CTRL_W (CTRL_W)
  ) u_rmux (
    .tgt        (tgt),
    .view_noflag(view_noflag),
    .view_exc   (view_exc),
    .priv       (priv),
    .rd_en      (rd_en),
    .proc_active(proc_active),
    .psw_in     (psw_in),
    .sp_live    (sp_live),
    .sp_banked  (sp_banked),
    .fmask_in   (fmask_in),
    .ctrl_in    (ctrl_in),
    .rdata      (rdata)
  );

  sreg_write_ctl #(
    .DATA_W (DATA_W),
    .FLAG_LO(FLAG_LO)
  ) u_wctl (
    .tgt         (tgt),
    .view_noflag (view_noflag),
    .priv        (priv),
    .wr_en       (wr_en),
    .proc_active (proc_active),
    .new_spsel   (wdata[SPSEL_BIT]),
    .psw_we      (psw_we),
    .psw_wmask   (psw_wmask),
    .live_sp_we  (live_sp_we),
    .banked_sp_we(banked_sp_we),
    .fmask_we    (fmask_we),
    .ctrl_we     (ctrl_we),
    .sp_swap     (sp_swap)
  );

  assign st_wdata = wr_en ? wdata : '0;
  assign sel_err  = (rd_en || wr_en) && (tgt == TGT_NONE);
endmodule

// File: rtl/sreg_access_unit_chk.sv
module sreg_access_unit_chk #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SEL_W   = 8,
  parameter int unsigned FLAG_LO = 27,
  parameter int unsigned EXC_W   = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SEL_W-1:0]  sel,
  input logic              rd_en,
  input logic              priv,
  input logic              new_spsel,
  input logic              cur_spsel,
  input logic [DATA_W-1:0] rdata,
  input logic              psw_we,
  input logic [DATA_W-1:0] psw_wmask,
  input logic              live_sp_we,
  input logic              banked_sp_we,
  input logic              fmask_we,
  input logic              ctrl_we,
  input logic              sp_swap,
  input logic              sel_err
);
  localparam logic [DATA_W-1:0] ONE       = DATA_W'(1);
  localparam logic [DATA_W-1:0] FLAG_MASK = ~((ONE << FLAG_LO) - ONE);
  localparam logic [DATA_W-1:0] EXC_MASK  = (ONE << EXC_W) - ONE;
  localparam logic [SEL_W-1:0]  VIEWS     = SEL_W'(8);

  logic any_we;
  assign any_we = psw_we || live_sp_we || banked_sp_we || fmask_we || ctrl_we;

  assert_unknown_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    sel_err |-> (rdata == '0) && !any_we && !sp_swap);

  assert_unpriv_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !priv |-> !(live_sp_we || banked_sp_we || fmask_we || ctrl_we || sp_swap));

  assert_flag_only_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    psw_we |-> (psw_wmask == FLAG_MASK) && (sel < VIEWS) && !sel[2]);

  assert_single_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({psw_we, live_sp_we, banked_sp_we, fmask_we, ctrl_we}));

  assert_swap_on_change_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sp_swap |-> ctrl_we && (new_spsel != cur_spsel));

  assert_idle_read_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rdata == '0));

  assert_unpriv_exc_hidden_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !priv && (sel < VIEWS)) |-> ((rdata & EXC_MASK) == '0));

  assert_exec_state_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (sel < VIEWS)) |-> ((rdata & ~(FLAG_MASK | EXC_MASK)) == '0));
endmodule

bind sreg_access_unit sreg_access_unit_chk #(
  .DATA_W (DATA_W),
  .SEL_W  (SEL_W),
  .FLAG_LO(FLAG_LO),
  .EXC_W  (EXC_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sel         (sel),
  .rd_en       (rd_en),
  .priv        (priv),
  .new_spsel   (wdata[SPSEL_BIT]),
  .cur_spsel   (ctrl_in[SPSEL_BIT]),
  .rdata       (rdata),
  .psw_we      (psw_we),
  .psw_wmask   (psw_wmask),
  .live_sp_we  (live_sp_we),
  .banked_sp_we(banked_sp_we),
  .fmask_we    (fmask_we),
  .ctrl_we     (ctrl_we),
  .sp_swap     (sp_swap),
  .sel_err     (sel_err)
);

// File: tb/sreg_access_unit_bench.sv
`timescale 1ns/1ps
module sreg_access_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  sel = '0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic        priv = 1'b0;
  logic [31:0] rdata, psw_wmask, st_wdata;
  logic        psw_we, live_sp_we, banked_sp_we, fmask_we, ctrl_we, sp_swap, sel_err;

  // modelled state elements outside the unit
  logic [31:0] env_psw = '0;
  logic [31:0] env_live = '0;
  logic [31:0] env_banked = '0;
  logic        env_fm = 1'b0;
  logic [1:0]  env_ctrl = '0;

  // values captured in the access cycle
  logic [31:0] c_rdata, c_wmask, c_wdata;
  logic        c_psw_we, c_live_we, c_banked_we, c_fm_we, c_ctrl_we, c_swap, c_err;

  int n_checks = 0;
  int n_errors = 0;

  always #2.5 clk = ~clk;

  sreg_access_unit u_sreg_access_unit (
    .clk(clk), .rst_n(rst_n), .sel(sel), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .priv(priv), .psw_in(env_psw), .sp_live(env_live),
    .sp_banked(env_banked), .fmask_in(env_fm), .ctrl_in(env_ctrl),
    .rdata(rdata), .psw_we(psw_we), .psw_wmask(psw_wmask),
    .live_sp_we(live_sp_we), .banked_sp_we(banked_sp_we), .fmask_we(fmask_we),
    .ctrl_we(ctrl_we), .sp_swap(sp_swap), .st_wdata(st_wdata), .sel_err(sel_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // one access: drive at a falling edge, capture 1 ns later, state loads at the rising edge
  task automatic access(input logic [7:0] s, input logic r, input logic w,
                        input logic [31:0] d, input logic p);
    @(negedge clk);
    sel = s; rd_en = r; wr_en = w; wdata = d; priv = p;
    #1;
    c_rdata = rdata; c_wmask = psw_wmask; c_wdata = st_wdata;
    c_psw_we = psw_we; c_live_we = live_sp_we; c_banked_we = banked_sp_we;
    c_fm_we = fmask_we; c_ctrl_we = ctrl_we; c_swap = sp_swap; c_err = sel_err;
    @(posedge clk);
    if (c_psw_we)    env_psw = (env_psw & ~c_wmask) | (c_wdata & c_wmask);
    if (c_live_we)   env_live = c_wdata;
    if (c_banked_we) env_banked = c_wdata;
    if (c_fm_we)     env_fm = c_wdata[0];
    if (c_ctrl_we)   env_ctrl = c_wdata[1:0];
    if (c_swap) begin
      logic [31:0] tmp;
      tmp = env_live; env_live = env_banked; env_banked = tmp;
    end
    rd_en = 1'b0; wr_en = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [7:0] s, input logic p);
    access(s, 1'b1, 1'b0, 32'h0, p);
  endtask

  task automatic wr(input logic [7:0] s, input logic [31:0] d, input logic p);
    access(s, 1'b0, 1'b1, d, p);
  endtask

  task automatic t_reset;
    @(negedge clk); #1;
    chk("R13 idle rdata after reset", rdata, 32'h0);
    chk("R12 idle sel_err after reset", {31'b0, sel_err}, 32'h0);
    chk("R13 idle st_wdata after reset", st_wdata, 32'h0);
  endtask

  task automatic t_psw_read;
    env_psw = 32'hFFFF_FFFF;
    rd(8'd0, 1'b1); chk("R1 view0 flags", c_rdata, 32'hF800_0000);
    rd(8'd1, 1'b1); chk("R2 view1 priv flags+exc", c_rdata, 32'hF800_01FF);
    rd(8'd1, 1'b0); chk("R2 view1 unpriv hides exc", c_rdata, 32'hF800_0000);
    rd(8'd2, 1'b1); chk("R3 view2 exec bits zero", c_rdata, 32'hF800_0000);
    rd(8'd3, 1'b1); chk("R3 view3 exec bits zero", c_rdata, 32'hF800_01FF);
    rd(8'd4, 1'b1); chk("R1 view4 no flags", c_rdata, 32'h0);
    rd(8'd5, 1'b1); chk("R1 view5 exc only", c_rdata, 32'h0000_01FF);
    rd(8'd5, 1'b0); chk("R2 view5 unpriv zero", c_rdata, 32'h0);
    rd(8'd7, 1'b1); chk("R3 view7 exc only", c_rdata, 32'h0000_01FF);
    env_psw = 32'h5000_0042;
    rd(8'd1, 1'b1); chk("R1 view1 pattern", c_rdata, 32'h5000_0042);
    chk("R12 view read no error", {31'b0, c_err}, 32'h0);
  endtask

  task automatic t_ctrl_read;
    env_ctrl = 2'b01;
    rd(8'd20, 1'b1); chk("R4 CONTROL priv", c_rdata, 32'h1);
    rd(8'd20, 1'b0); chk("R4 CONTROL unpriv", c_rdata, 32'h1);
    env_ctrl = 2'b00;
  endtask

  task automatic t_unpriv_read;
    env_live = 32'h1111_0000; env_banked = 32'h2222_0000; env_fm = 1'b1;
    rd(8'd8, 1'b0);  chk("R5 unpriv main sp", c_rdata, 32'h0);
    chk("R5 unpriv no error", {31'b0, c_err}, 32'h0);
    rd(8'd9, 1'b0);  chk("R5 unpriv proc sp", c_rdata, 32'h0);
    rd(8'd19, 1'b0); chk("R5 unpriv fault mask", c_rdata, 32'h0);
  endtask

  task automatic t_sp_read;
    env_live = 32'h1111_0000; env_banked = 32'h2222_0000; env_ctrl = 2'b00;
    rd(8'd8, 1'b1); chk("R6 main active main", c_rdata, 32'h1111_0000);
    rd(8'd9, 1'b1); chk("R6 main active proc", c_rdata, 32'h2222_0000);
    env_ctrl = 2'b10;
    rd(8'd8, 1'b1); chk("R6 proc active main", c_rdata, 32'h2222_0000);
    rd(8'd9, 1'b1); chk("R6 proc active proc", c_rdata, 32'h1111_0000);
    env_ctrl = 2'b00;
  endtask

  task automatic t_fmask_read;
    env_fm = 1'b1;
    rd(8'd19, 1'b1); chk("R7 fault mask set", c_rdata, 32'h1);
    env_fm = 1'b0;
    rd(8'd19, 1'b1); chk("R7 fault mask clear", c_rdata, 32'h0);
  endtask

  task automatic t_psw_write;
    env_psw = 32'h0700_0123;
    wr(8'd0, 32'hFFFF_FFFF, 1'b0); chk("R8 unpriv flag write", env_psw, 32'hFF00_0123);
    wr(8'd4, 32'h0000_0000, 1'b1); chk("R8 view4 write ignored", env_psw, 32'hFF00_0123);
    wr(8'd3, 32'h0000_0000, 1'b1); chk("R8 view3 clears flags only", env_psw, 32'h0700_0123);
    wr(8'd1, 32'hA8FF_FFFF, 1'b0); chk("R8 view1 flag pattern", env_psw, 32'hAF00_0123);
    wr(8'd6, 32'hFFFF_FFFF, 1'b1); chk("R8 view6 write ignored", env_psw, 32'hAF00_0123);
  endtask

  task automatic t_unpriv_write;
    env_live = 32'hAAAA_0000; env_banked = 32'hBBBB_0000; env_fm = 1'b0; env_ctrl = 2'b00;
    wr(8'd8, 32'h1234_5678, 1'b0);  chk("R9 unpriv main sp", env_live, 32'hAAAA_0000);
    chk("R9 unpriv no error", {31'b0, c_err}, 32'h0);
    wr(8'd9, 32'h1234_5678, 1'b0);  chk("R9 unpriv proc sp", env_banked, 32'hBBBB_0000);
    wr(8'd19, 32'h1, 1'b0);         chk("R9 unpriv fault mask", {31'b0, env_fm}, 32'h0);
    wr(8'd20, 32'h3, 1'b0);         chk("R9 unpriv CONTROL", {30'b0, env_ctrl}, 32'h0);
    chk("R9 unpriv no swap", {31'b0, c_swap}, 32'h0);
  endtask

  task automatic t_priv_write;
    env_ctrl = 2'b00;
    wr(8'd8, 32'h0000_1000, 1'b1); chk("R10 main sp to live", env_live, 32'h0000_1000);
    wr(8'd9, 32'h0000_2000, 1'b1); chk("R10 proc sp to banked", env_banked, 32'h0000_2000);
    env_ctrl = 2'b10;
    wr(8'd8, 32'h0000_3000, 1'b1); chk("R10 main sp to banked", env_banked, 32'h0000_3000);
    chk("R10 live untouched", env_live, 32'h0000_1000);
    wr(8'd19, 32'h0000_0001, 1'b1); chk("R10 fault mask set", {31'b0, env_fm}, 32'h1);
    wr(8'd19, 32'hFFFF_FFFE, 1'b1); chk("R10 fault mask bit0", {31'b0, env_fm}, 32'h0);
    env_ctrl = 2'b00;
  endtask

  task automatic t_ctrl_swap;
    env_ctrl = 2'b00; env_live = 32'h0000_A000; env_banked = 32'h0000_B000;
    wr(8'd20, 32'h2, 1'b1);
    chk("R11 swap raised", {31'b0, c_swap}, 32'h1);
    chk("R10 CONTROL loaded", {30'b0, env_ctrl}, 32'h2);
    chk("R11 live now proc", env_live, 32'h0000_B000);
    rd(8'd8, 1'b1); chk("R11 main sp after swap", c_rdata, 32'h0000_A000);
    wr(8'd20, 32'h3, 1'b1);
    chk("R11 no swap same bit", {31'b0, c_swap}, 32'h0);
    chk("R11 live unchanged", env_live, 32'h0000_B000);
    env_ctrl = 2'b00;
  endtask

  task automatic t_unknown;
    env_psw = 32'h1234_5678; env_live = 32'h11; env_banked = 32'h22; env_fm = 1'b0; env_ctrl = 2'b00;
    rd(8'd12, 1'b1);
    chk("R12 unknown read zero", c_rdata, 32'h0);
    chk("R12 unknown read error", {31'b0, c_err}, 32'h1);
    @(negedge clk); #1;
    chk("R12 error one cycle", {31'b0, sel_err}, 32'h0);
    wr(8'hFF, 32'hFFFF_FFFF, 1'b1);
    chk("R12 unknown write error", {31'b0, c_err}, 32'h1);
    chk("R12 psw kept", env_psw, 32'h1234_5678);
    chk("R12 stacks kept", env_live ^ env_banked, 32'h33);
    chk("R12 mask ctrl kept", {29'b0, env_fm, env_ctrl}, 32'h0);
    rd(8'd16, 1'b0);
    chk("R12 unpriv unknown error", {31'b0, c_err}, 32'h1);
  endtask

  task automatic t_idle_read;
    env_ctrl = 2'b11;
    @(negedge clk);
    sel = 8'd20; rd_en = 1'b0; wr_en = 1'b0; wdata = 32'hDEAD_BEEF; priv = 1'b1;
    #1;
    chk("R13 no strobe rdata", rdata, 32'h0);
    chk("R13 no strobe st_wdata", st_wdata, 32'h0);
    env_ctrl = 2'b00;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_psw_read();
    t_ctrl_read();
    t_unpriv_read();
    t_sp_read();
    t_fmask_read();
    t_psw_write();
    t_unpriv_write();
    t_priv_write();
    t_ctrl_swap();
    t_unknown();
    t_idle_read();
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule